// File: doc/BRIEF.md
# Single-Window Cartridge Bank Mapper

This block sits on an 8-bit cartridge bus with a 64KB CPU address space. It places a 256KB flash device and a 32KB static RAM into that space. The space is split into four 16KB pages:

- The two lowest pages always show flash banks 0 and 1.
- The page at 0x8000 is a window that can show any of the sixteen 16KB flash banks.
- The top page belongs to the SRAM.

Software picks the window's bank by writing to any address in the read-only area 0x0000–0xBFFF. That write never reaches the flash. The low four data bits of the write become the bank number, which drives flash address lines 17 down to 14 whenever the window is read.

The mapper samples the bus strobes on a local clock and loads the bank register once per write strobe. Both chip selects are formed combinationally from the current bus state. The console's own work RAM is taken to be switched off by the cartridge, so the SRAM page never contends with it.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the bank register holds 2, so a read of 0x8000 drives flash_addr[17:14] = 4'd2.
- R2: A memory read in 0x0000–0x7FFF drives flash_addr[17:14] = {2'b00, cpu_addr[15:14]}, whatever the bank register holds.
- R3: A memory read in 0x8000–0xBFFF drives flash_addr[17:14] from the bank register.
- R4: A memory write (mreq_n=0, iorq_n=1, wr_n=0) to any address in 0x0000–0xBFFF loads cpu_data[3:0] into the bank register. Bit 3 goes to flash A17 and bit 0 to A14, and cpu_data[7:4] are ignored. The new bank is visible from the clock edge that follows the strobe's rise.
- R5: Only the rising edge of the write strobe loads the register. Data that changes while the strobe stays active is not taken.
- R6: Memory writes to 0xC000–0xFFFF and I/O writes leave the bank register unchanged.
- R7: flash_ce_n is low only for memory reads in 0x0000–0xBFFF. It stays high during page writes.
- R8: sram_ce_n is low for memory reads and writes in 0xC000–0xFFFF and high elsewhere.
- R9: Both chip selects are high while mreq_n is high or iorq_n is low.
- R10: flash_addr[13:0] and sram_addr both equal cpu_addr[13:0], so only 16KB of the SRAM is reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the bus strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus as seen during writes |
| mreq_n | input | 1 | Active-low memory request |
| iorq_n | input | 1 | Active-low I/O request |
| wr_n | input | 1 | Active-low write strobe |
| flash_addr | output | 18 | Flash address, bank bits on top |
| flash_ce_n | output | 1 | Active-low flash chip enable |
| sram_addr | output | 14 | SRAM address |
| sram_ce_n | output | 1 | Active-low SRAM chip enable |

## Verification
The assertions rely on the address and data being stable while a write strobe is active. They also rely on no write strobe being active when reset is released, so that the first sampled strobe edge is a real one. The bench changes bus signals only on falling clock edges and holds each write for at least one full clock period. It also keeps every strobe inactive during reset, so every loaded bank follows one clean strobe rise.

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 14,
  parameter int BANK_W     = 4,
  parameter int RESET_BANK = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [7:0]               cpu_data,
  input  logic                     mreq_n,
  input  logic                     iorq_n,
  input  logic                     wr_n,
  output logic [PAGE_W+BANK_W-1:0] flash_addr,
  output logic                     flash_ce_n,
  output logic [PAGE_W-1:0]        sram_addr,
  output logic                     sram_ce_n
);
  localparam int SEL_W = ADDR_W - PAGE_W;

  logic [SEL_W-1:0]  page_sel;
  logic              mem_cyc, in_rom, in_window, wr_stb, wr_stb_q;
  logic [BANK_W-1:0] bank_q;

  assign page_sel  = cpu_addr[ADDR_W-1:PAGE_W];
  assign mem_cyc   = !mreq_n && iorq_n;
  assign in_rom    = page_sel != '1;
  assign in_window = page_sel == SEL_W'(2);
  assign wr_stb    = mem_cyc && !wr_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_stb_q <= 1'b0;
      bank_q   <= BANK_W'(RESET_BANK);
    end else begin
      wr_stb_q <= wr_stb;
      if (wr_stb && !wr_stb_q && in_rom)
        bank_q <= cpu_data[BANK_W-1:0];
    end

  assign flash_addr[PAGE_W-1:0]             = cpu_addr[PAGE_W-1:0];
  assign flash_addr[PAGE_W+BANK_W-1:PAGE_W] = in_window ? bank_q : BANK_W'(page_sel);
  assign sram_addr  = cpu_addr[PAGE_W-1:0];
  assign flash_ce_n = !(mem_cyc && in_rom && wr_n);
  assign sram_ce_n  = !(mem_cyc && !in_rom);
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_data,
  input logic        mreq_n,
  input logic        iorq_n,
  input logic        wr_n,
  input logic [17:0] flash_addr,
  input logic        flash_ce_n,
  input logic        sram_ce_n,
  input logic [3:0]  bank_q
);
  logic mwr;
  assign mwr = !mreq_n && iorq_n && !wr_n;

  // R4
  rom_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr && !$past(mwr) && cpu_addr < 16'hC000) |=> bank_q == $past(cpu_data[3:0]));

  // R6
  bank_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mwr && !$past(mwr) && cpu_addr < 16'hC000) |=> $stable(bank_q));

  // R7
  flash_only_rom_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_ce_n |-> (cpu_addr < 16'hC000 && wr_n));

  // R8
  sram_only_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> cpu_addr[15:14] == 2'b11);

  // R9
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_n || !iorq_n) |-> (flash_ce_n && sram_ce_n));

  // R3
  window_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b10) |-> flash_addr[17:14] == bank_q);
endmodule

bind cart_bank_mapper cart_bank_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
  .mreq_n(mreq_n), .iorq_n(iorq_n), .wr_n(wr_n), .flash_addr(flash_addr),
  .flash_ce_n(flash_ce_n), .sram_ce_n(sram_ce_n), .bank_q(bank_q)
);

// File: tb/cart_bank_mapper_bench.sv
module cart_bank_mapper_bench;
  logic        clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_data = 0;
  logic        mreq_n = 1, iorq_n = 1, wr_n = 1;
  logic [17:0] flash_addr;
  logic [13:0] sram_addr;
  logic        flash_ce_n, sram_ce_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cart_bank_mapper u_cart_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .wr_n(wr_n), .flash_addr(flash_addr),
    .flash_ce_n(flash_ce_n), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    mreq_n = 1; iorq_n = 1; wr_n = 1;
  endtask

  task automatic mem_write(logic [15:0] a, logic [7:0] d, output logic fce, output logic sce);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; mreq_n = 0; iorq_n = 1; wr_n = 0;
    #1 fce = flash_ce_n; sce = sram_ce_n;
    idle();
  endtask

  task automatic read_bank(logic [15:0] a, output logic [3:0] b, output logic fce);
    @(negedge clk);
    cpu_addr = a; mreq_n = 0; iorq_n = 1; wr_n = 1;
    #1 b = flash_addr[17:14]; fce = flash_ce_n;
    idle();
  endtask

  task automatic t_reset();
    logic [3:0] b; logic f;
    check("R9 reset idle flash_ce_n", flash_ce_n, 1);
    check("R9 reset idle sram_ce_n", sram_ce_n, 1);
    read_bank(16'h8000, b, f);
    check("R1 reset bank", b, 2);
  endtask

  task automatic t_fixed_pages();
    logic [3:0] b; logic f;
    read_bank(16'h0123, b, f);
    check("R2 page0 bank", b, 0);
    check("R7 page0 read flash_ce_n", f, 0);
    read_bank(16'h7FFF, b, f);
    check("R2 page1 bank", b, 1);
  endtask

  task automatic t_window_load();
    logic [3:0] b; logic f, s;
    mem_write(16'h8000, 8'hA5, f, s);
    check("R7 page write flash_ce_n", f, 1);
    check("R8 page write sram_ce_n", s, 1);
    read_bank(16'hBFFF, b, f);
    check("R4 window bank after write 0xA5", b, 5);
    check("R3 window read flash_ce_n", f, 0);
    mem_write(16'h2000, 8'h0C, f, s);
    read_bank(16'h9000, b, f);
    check("R4 write to page0 loads bank", b, 4'hC);
    read_bank(16'h4000, b, f);
    check("R2 page1 ignores bank", b, 1);
    mem_write(16'h4321, 8'hF3, f, s);
    read_bank(16'h8001, b, f);
    check("R4 upper data bits ignored", b, 3);
  endtask

  task automatic t_edge_only();
    logic [3:0] b; logic f;
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_data = 8'h07; mreq_n = 0; iorq_n = 1; wr_n = 0;
    @(negedge clk); cpu_data = 8'h09;
    @(negedge clk); cpu_data = 8'h0E;
    @(negedge clk);
    idle();
    read_bank(16'h8000, b, f);
    check("R5 held strobe loads once", b, 7);
  endtask

  task automatic t_no_load();
    logic [3:0] b; logic f, s;
    mem_write(16'hC000, 8'h0B, f, s);
    check("R8 sram write sram_ce_n", s, 0);
    check("R7 sram write flash_ce_n", f, 1);
    read_bank(16'h8000, b, f);
    check("R6 sram write keeps bank", b, 7);
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_data = 8'h01; mreq_n = 1; iorq_n = 0; wr_n = 0;
    #1 check("R9 io flash_ce_n", flash_ce_n, 1);
    check("R9 io sram_ce_n", sram_ce_n, 1);
    idle();
    read_bank(16'h8000, b, f);
    check("R6 io write keeps bank", b, 7);
  endtask

  task automatic t_sram_addr();
    @(negedge clk);
    cpu_addr = 16'hF2A7; mreq_n = 0; iorq_n = 1; wr_n = 1;
    #1 check("R8 sram read sram_ce_n", sram_ce_n, 0);
    check("R7 sram read flash_ce_n", flash_ce_n, 1);
    check("R10 sram_addr", sram_addr, 14'h32A7);
    check("R10 flash low addr", flash_addr[13:0], 14'h32A7);
    mreq_n = 1;
    #1 check("R9 no mreq sram_ce_n", sram_ce_n, 1);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fixed_pages();
    t_window_load();
    t_edge_only();
    t_no_load();
    t_sram_addr();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule